// File: doc/BRIEF.md
# Byte-lane receive FIFO with threshold-driven DMA request

This block sits between a byte-wide deserializer and a system bus that is either 16 or 32 bits wide. Received bytes arrive one per cycle with a valid strobe. A lane index steers each byte into one byte lane of the word being assembled. The order of the lanes follows an endianness input. A word is committed when its last lane is written, or earlier when an end-of-packet strobe arrives with a byte. The store holds 8 words of 4 bytes each. The depth is a parameter and must be a power of two.

A 2-bit threshold sets how many held words raise the DMA request. In block mode, each burst moves exactly the threshold number of words. In fill/empty mode, a burst keeps going until the store is empty. The bus side sees the head word combinationally on `rd_data`, along with the count of its valid bytes. It accepts a word by asserting `rd_en` during a cycle in which `dma_req` is high. A byte that arrives when the store is full is discarded and sets a sticky overflow flag.

Top module: `rx_lane_fifo`

## Requirements
- R1: The store holds at most DEPTH (8) committed words. A byte offered while all DEPTH words are committed is not stored.
- R2: With `cfg_big`=0, the first byte of a word goes to bits 7:0 and each later byte goes to the next higher lane.
- R3: With `cfg_big`=1 and `cfg_wide`=1, the first byte goes to bits 31:24 and each later byte goes to the next lower lane.
- R4: With `cfg_wide`=0, a word holds two bytes and bits 31:16 read as zero. The first byte goes to bits 7:0 when `cfg_big`=0 and to bits 15:8 when `cfg_big`=1.
- R5: `cfg_thresh` values 0, 1, 2 and 3 mean 2, 4, 8 and 12 bytes. The threshold in words is that byte count divided by the word size (4 or 2), rounded down, with a minimum of 1 and a maximum of DEPTH. `dma_req` stays low while fewer words are held than the threshold and no end of packet is pending. It rises once the threshold is reached.
- R6: With `cfg_fill`=0, a burst ends after exactly the threshold number of accepted reads. `dma_req` then drops for at least one cycle.
- R7: With `cfg_fill`=1, `dma_req` stays high until every held word has been read.
- R8: `rd_en` pops the head word only while `dma_req` is high. At any other time it has no effect.
- R9: A byte that carries `in_eop` commits the word even if the word is only partly filled. A burst is then raised whatever the threshold. In block mode that burst is the smaller of the threshold and the number of held words.
- R10: `rd_bytes` gives the number of valid bytes (1 to 4) in the head word.
- R11: A dropped byte sets `overflow`, and `overflow` stays set until it is cleared.
- R12: `status_clr` clears `overflow`. A drop in the same cycle takes precedence and keeps the flag set.
- R13: After reset, `dma_req` and `overflow` are low and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 = 32-bit words, 0 = 16-bit words |
| cfg_big | input | 1 | 1 = big-endian lane order |
| cfg_fill | input | 1 | 1 = fill/empty burst mode, 0 = block mode |
| cfg_thresh | input | 2 | Threshold code (2/4/8/12 bytes) |
| in_valid | input | 1 | Incoming byte valid |
| in_byte | input | 8 | Incoming byte |
| in_eop | input | 1 | Marks the valid byte as the last one of a packet |
| rd_en | input | 1 | Bus accepts the head word this cycle |
| status_clr | input | 1 | Clears the overflow flag |
| rd_data | output | 32 | Head word |
| rd_bytes | output | 3 | Valid byte count of the head word |
| dma_req | output | 1 | DMA transfer request |
| overflow | output | 1 | Sticky overflow flag |

## Verification
The bench loads each lane order in both bus widths and compares the exact packed words. A design with the endian index reversed, or one that fails to clear stale upper lanes, would return scrambled or polluted words. It measures the burst length in both modes and with a partial word at end of packet. An off-by-one in the burst counter, or a threshold that ignores the word size, shows up there as too many or too few reads per request. Stray `rd_en` pulses while the request is low would make a design that pops without permission lose the head word. A 33-byte fill checks that only the extra byte is dropped, that the flag stays set, and that it clears on request.

// File: rtl/rx_lane_fifo.sv
module rx_lane_fifo #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wide,
  input  logic        cfg_big,
  input  logic        cfg_fill,
  input  logic [1:0]  cfg_thresh,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        in_eop,
  input  logic        rd_en,
  input  logic        status_clr,
  output logic [31:0] rd_data,
  output logic [2:0]  rd_bytes,
  output logic        dma_req,
  output logic        overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]   mem    [DEPTH];
  logic [2:0]    nbytes [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, left, thr_w, blen;
  logic [1:0]    idx;
  logic [4:0]    thr_bytes, thr_raw;
  logic          busy, eop_pend, ovf;

  wire       full      = count == CW'(DEPTH);
  wire       accept    = in_valid && !full;
  wire [1:0] last_idx  = cfg_wide ? 2'd3 : 2'd1;
  wire [1:0] lane      = cfg_big ? last_idx - idx : idx;
  wire       commit    = accept && (idx == last_idx || in_eop);
  wire       pop       = rd_en && busy;
  wire       start     = !busy && count != '0 && (count >= thr_w || eop_pend);
  wire       burst_end = cfg_fill ? (count == CW'(1) && !commit) : (left == CW'(1));

  always_comb begin
    case (cfg_thresh)
      2'd0:    thr_bytes = 5'd2;
      2'd1:    thr_bytes = 5'd4;
      2'd2:    thr_bytes = 5'd8;
      default: thr_bytes = 5'd12;
    endcase
    thr_raw = cfg_wide ? (thr_bytes >> 2) : (thr_bytes >> 1);
    if (thr_raw == 5'd0)            thr_w = CW'(1);
    else if (int'(thr_raw) > DEPTH) thr_w = CW'(DEPTH);
    else                            thr_w = CW'(thr_raw);
    blen = (cfg_fill || count < thr_w) ? count : thr_w;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      if (idx == 2'd0) mem[wr_ptr] <= {24'd0, in_byte} << {lane, 3'b000};
      else             mem[wr_ptr][{lane, 3'b000} +: 8] <= in_byte;
      if (commit) nbytes[wr_ptr] <= {1'b0, idx} + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      left     <= '0;
      idx      <= '0;
      busy     <= 1'b0;
      eop_pend <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (accept) begin
        if (commit) begin
          wr_ptr <= wr_ptr + 1'b1;
          idx    <= '0;
        end else begin
          idx <= idx + 2'd1;
        end
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(commit) - CW'(pop);

      if (commit && in_eop)  eop_pend <= 1'b1;
      else if (count == '0)  eop_pend <= 1'b0;

      if (start) begin
        busy <= 1'b1;
        left <= blen;
      end else if (pop) begin
        if (burst_end) busy <= 1'b0;
        left <= left - 1'b1;
      end

      if (in_valid && full) ovf <= 1'b1;
      else if (status_clr)  ovf <= 1'b0;
    end
  end

  assign rd_data  = mem[rd_ptr];
  assign rd_bytes = nbytes[rd_ptr];
  assign dma_req  = busy;
  assign overflow = ovf;
endmodule

// File: rtl/rx_lane_fifo_chk.sv
module rx_lane_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_req,
  input logic          overflow,
  input logic          status_clr,
  input logic          in_valid,
  input logic [CW-1:0] count,
  input logic [2:0]    rd_bytes
);
  a_r1_no_excess: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r8_req_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> count != '0);
  a_r10_head_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rd_bytes != 3'd0);
  a_r11_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && count == CW'(DEPTH)) |=> overflow);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !status_clr) |=> overflow);
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !(in_valid && count == CW'(DEPTH))) |=> !overflow);
endmodule

bind rx_lane_fifo rx_lane_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .overflow(overflow),
  .status_clr(status_clr), .in_valid(in_valid), .count(count), .rd_bytes(rd_bytes)
);

// File: tb/rx_lane_fifo_test.sv
module rx_lane_fifo_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wide = 1'b1, cfg_big = 1'b0, cfg_fill = 1'b0;
  logic [1:0] cfg_thresh = 2'd0;
  logic in_valid = 1'b0, in_eop = 1'b0, rd_en = 1'b0, status_clr = 1'b0;
  logic [7:0] in_byte = 8'd0;
  logic [31:0] rd_data;
  logic [2:0] rd_bytes;
  logic dma_req, overflow;

  int n_cmp = 0, n_bad = 0, n_got = 0;
  logic [31:0] got  [16];
  logic [2:0]  gotb [16];

  always #10ns clk = ~clk;

  rx_lane_fifo uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b, logic e);
    in_valid = 1'b1; in_byte = b; in_eop = e;
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 20 && !dma_req; i++) @(negedge clk);
  endtask

  task automatic read_burst();
    n_got = 0;
    while (dma_req && n_got < 16) begin
      got[n_got] = rd_data; gotb[n_got] = rd_bytes; rd_en = 1'b1;
      @(negedge clk);
      n_got++;
    end
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R13 dma_req", 32'(dma_req), 0);
    check("R13 overflow", 32'(overflow), 0);
  endtask

  task automatic t_little32();
    cfg_wide = 1; cfg_big = 0; cfg_fill = 0; cfg_thresh = 2'd2;
    for (int i = 1; i <= 8; i++) push(8'(i), 0);
    wait_req(); read_burst();
    check("R6 burst len", n_got, 2);
    check("R2 word0", got[0], 32'h04030201);
    check("R2 word1", got[1], 32'h08070605);
    check("R10 full bytes", 32'(gotb[0]), 4);
  endtask

  task automatic t_big32();
    cfg_wide = 1; cfg_big = 1; cfg_fill = 0; cfg_thresh = 2'd1;
    push(8'h11, 0); push(8'h22, 0); push(8'h33, 0); push(8'h44, 0);
    wait_req(); read_burst();
    check("R3 burst len", n_got, 1);
    check("R3 word", got[0], 32'h11223344);
  endtask

  task automatic t_half(logic big);
    cfg_wide = 0; cfg_big = big; cfg_fill = 0; cfg_thresh = 2'd1;
    push(8'ha1, 0); push(8'ha2, 0); push(8'ha3, 0); push(8'ha4, 0);
    wait_req(); read_burst();
    check("R5 half thr words", n_got, 2);
    check("R4 half word0", got[0], big ? 32'h0000a1a2 : 32'h0000a2a1);
    check("R4 half word1", got[1], big ? 32'h0000a3a4 : 32'h0000a4a3);
    check("R10 half bytes", 32'(gotb[0]), 2);
  endtask

  task automatic t_threshold();
    cfg_wide = 1; cfg_big = 0; cfg_fill = 0; cfg_thresh = 2'd3;
    for (int i = 0; i < 8; i++) push(8'h20 + 8'(i), 0);
    repeat (3) @(negedge clk);
    check("R5 below thr", 32'(dma_req), 0);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    for (int i = 8; i < 12; i++) push(8'h20 + 8'(i), 0);
    wait_req();
    check("R5 reached", 32'(dma_req), 1);
    read_burst();
    check("R6 thr3 len", n_got, 3);
    check("R8 ignored read", got[0], 32'h23222120);
    check("R8 last word", got[2], 32'h2b2a2928);
  endtask

  task automatic t_block_bursts();
    cfg_wide = 1; cfg_big = 0; cfg_fill = 0; cfg_thresh = 2'd0;
    for (int i = 0; i < 12; i++) push(8'h40 + 8'(i), 0);
    for (int b = 0; b < 3; b++) begin
      wait_req(); read_burst();
      check("R6 one-word burst", n_got, 1);
      check("R6 burst data", got[0], {8'h43, 8'h42, 8'h41, 8'h40} + 32'h04040404 * b);
    end
    repeat (3) @(negedge clk);
    check("R6 drained", 32'(dma_req), 0);
  endtask

  task automatic t_fill();
    cfg_wide = 1; cfg_big = 0; cfg_fill = 1; cfg_thresh = 2'd0;
    for (int i = 0; i < 12; i++) push(8'h60 + 8'(i), 0);
    wait_req(); read_burst();
    check("R7 fill len", n_got, 3);
    check("R7 fill last", got[2], 32'h6b6a6968);
  endtask

  task automatic t_eop();
    cfg_wide = 1; cfg_big = 0; cfg_fill = 0; cfg_thresh = 2'd3;
    for (int i = 1; i <= 5; i++) push(8'(i), i == 5);
    wait_req(); read_burst();
    check("R9 eop burst len", n_got, 2);
    check("R9 partial word", got[1], 32'h00000005);
    check("R10 partial bytes", 32'(gotb[1]), 1);
    check("R10 whole bytes", 32'(gotb[0]), 4);
    cfg_big = 1;
    push(8'h55, 1);
    wait_req(); read_burst();
    check("R9 big partial", got[0], 32'h55000000);
    cfg_wide = 0;
    push(8'h66, 1);
    wait_req(); read_burst();
    check("R9 half big partial", got[0], 32'h00006600);
    check("R10 half partial", 32'(gotb[0]), 1);
  endtask

  task automatic t_overflow();
    cfg_wide = 1; cfg_big = 0; cfg_fill = 1; cfg_thresh = 2'd0;
    for (int i = 1; i <= 32; i++) push(8'(i), 0);
    check("R11 not yet", 32'(overflow), 0);
    push(8'hee, 0);
    check("R11 set", 32'(overflow), 1);
    read_burst();
    check("R1 held words", n_got, 8);
    check("R1 last kept", got[7], 32'h201f1e1d);
    repeat (2) @(negedge clk);
    check("R11 sticky", 32'(overflow), 1);
    status_clr = 1'b1; @(negedge clk); status_clr = 1'b0;
    check("R12 cleared", 32'(overflow), 0);
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_little32();
    t_big32();
    t_half(1'b0);
    t_half(1'b1);
    t_threshold();
    t_block_bursts();
    t_fill();
    t_eop();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule